// File: doc/BRIEF.md
# Machine check status and interrupt logic

This block holds the processor's machine-check status word and decides when to request a machine-check interrupt. Seven hardware error sources report through single-cycle pulses. Five of them are dedicated lines: instruction-fetch bus, data-read bus, data-write bus, TLB parity and instruction-cache parity. The data cache reports on one parity line. A companion signal tells whether that error came from a search or from a flush.

Each event latches a cause flag and the summary flag in the same clock edge. An interrupt request is raised while the summary flag is set and the machine-check enable bit from the machine state register is 1. If an event arrives while that enable bit is 0, a separate imprecise flag records that the check could not be taken.

Software reaches the word through a special-purpose-register port at number 0x23C. Only supervisor code can read it or clear it. Clearing is write-one-to-clear.

Top module: `mcs_unit`

## Requirements
- R1: While rst_ni is low, every status bit is 0 and mc_irq_o is 0.
- R2: Read data layout, with bit 0 as the LSB of spr_rdata_o: bit 0 is the summary, bit 1 instruction-fetch bus, bit 2 data-read bus, bit 3 data-write bus, bit 4 TLB parity, bit 5 instruction-cache parity, bit 6 data-cache parity during search, bit 7 data-cache parity during flush, bit 8 the imprecise flag. Bits 31..9 always read 0.
- R3: An error pulse sampled at a rising edge sets its cause bit and the summary bit at that same edge. Pulses that arrive together set all of their cause bits.
- R4: mc_irq_o equals the summary bit AND me_en_i, combinationally, at all times.
- R5: An error pulse sampled while me_en_i is 0 sets the imprecise flag, whether or not the summary bit was already set. A pulse sampled while me_en_i is 1 does not set it.
- R6: A pulse on dc_par_err_i sets bit 6 if dc_flush_op_i is 0 and bit 7 if it is 1, never both.
- R7: Flags are sticky. A supervisor write to SPR 0x23C clears exactly the bits 0..8 that are 1 in spr_wdata_i. Clearing only the summary leaves the cause bits and the imprecise flag intact and drops mc_irq_o.
- R8: When a clear and a setting event hit the same bit in the same cycle, the bit ends up set.
- R9: In user mode (supervisor_i = 0), a read of SPR 0x23C returns 0 and pulses priv_viol_o in that cycle. A write in user mode leaves the status unchanged.
- R10: An access with any other SPR number reads 0, changes nothing and does not raise priv_viol_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| me_en_i | input | 1 | Machine-check enable from the machine state register |
| err_ifetch_bus_i | input | 1 | Instruction-fetch bus error pulse |
| err_dread_bus_i | input | 1 | Data-read bus error pulse |
| err_dwrite_bus_i | input | 1 | Data-write bus error pulse |
| err_tlb_par_i | input | 1 | TLB parity error pulse |
| err_icache_par_i | input | 1 | Instruction-cache parity error pulse |
| dc_par_err_i | input | 1 | Data-cache parity error pulse |
| dc_flush_op_i | input | 1 | Qualifies dc_par_err_i: 1 flush, 0 search |
| spr_num_i | input | 10 | SPR number of the access |
| spr_rd_i | input | 1 | SPR read strobe |
| spr_wr_i | input | 1 | SPR write strobe |
| spr_wdata_i | input | 32 | SPR write data (write-one-to-clear mask) |
| supervisor_i | input | 1 | 1 when the access is from supervisor mode |
| spr_rdata_o | output | 32 | SPR read data, combinational |
| priv_viol_o | output | 1 | Pulse on a user-mode read of this register |
| mc_irq_o | output | 1 | Machine-check interrupt request |

## Verification
The bench targets several corner cases, and for each it names what a faulty design would show.

- A clear and an event on the same bit in one cycle: a design that lets the clear win loses an error.
- An event that arrives with machine checks disabled while the summary is already set: a design that keys the imprecise flag only on the summary's rising edge misses it.
- A summary-only clear: a design that wipes the cause bits with it destroys the diagnosis.
- A data-cache error under each operation: swapped or shared search and flush bits show up at once.
- Writes of all ones and user-mode or mis-addressed accesses: leaking reserved bits, granting user access, or decoding the SPR number loosely appear as nonzero data or cleared flags.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int unsigned NUM_CAUSE = 7;
  localparam int unsigned STATE_W   = NUM_CAUSE + 2;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned SPR_W     = 10;
  localparam logic [SPR_W-1:0] SPR_MCS = 10'h23C;

  // cause index within the cause field (bit = index + 1 in the SPR word)
  localparam int unsigned C_IFETCH = 0;
  localparam int unsigned C_DREAD  = 1;
  localparam int unsigned C_DWRITE = 2;
  localparam int unsigned C_TLB    = 3;
  localparam int unsigned C_ICACHE = 4;
  localparam int unsigned C_DSRCH  = 5;
  localparam int unsigned C_DFLUSH = 6;

  // last member is LSB: sum at bit 0, causes 1..7, imp at 8
  typedef struct packed {
    logic                 imp;
    logic [NUM_CAUSE-1:0] cause;
    logic                 sum;
  } mcs_state_t;
endpackage

// File: rtl/mcs_cause_decode.sv
module mcs_cause_decode
  import mcs_pkg::*;
(
  input  logic                 err_ifetch_bus_i,
  input  logic                 err_dread_bus_i,
  input  logic                 err_dwrite_bus_i,
  input  logic                 err_tlb_par_i,
  input  logic                 err_icache_par_i,
  input  logic                 dc_par_err_i,
  input  logic                 dc_flush_op_i,
  output logic [NUM_CAUSE-1:0] cause_set_o
);
  always_comb begin
    cause_set_o           = '0;
    cause_set_o[C_IFETCH] = err_ifetch_bus_i;
    cause_set_o[C_DREAD]  = err_dread_bus_i;
    cause_set_o[C_DWRITE] = err_dwrite_bus_i;
    cause_set_o[C_TLB]    = err_tlb_par_i;
    cause_set_o[C_ICACHE] = err_icache_par_i;
    cause_set_o[C_DSRCH]  = dc_par_err_i & ~dc_flush_op_i;
    cause_set_o[C_DFLUSH] = dc_par_err_i &  dc_flush_op_i;
  end
endmodule

// File: rtl/mcs_spr_port.sv
module mcs_spr_port
  import mcs_pkg::*;
#(
  parameter int unsigned          NUM_W  = SPR_W,
  parameter int unsigned          DW     = DATA_W,
  parameter logic [NUM_W-1:0]     MY_NUM = SPR_MCS
) (
  input  logic [NUM_W-1:0]   spr_num_i,
  input  logic               spr_rd_i,
  input  logic               spr_wr_i,
  input  logic [DW-1:0]      spr_wdata_i,
  input  logic               supervisor_i,
  input  mcs_state_t         state_i,
  output logic [STATE_W-1:0] clr_o,
  output logic [DW-1:0]      spr_rdata_o,
  output logic               priv_viol_o
);
  logic hit;
  assign hit = (spr_num_i == MY_NUM);

  always_comb begin
    clr_o       = '0;
    spr_rdata_o = '0;
    priv_viol_o = 1'b0;
    if (hit && supervisor_i) begin
      if (spr_wr_i) clr_o = spr_wdata_i[STATE_W-1:0];
      if (spr_rd_i) spr_rdata_o[STATE_W-1:0] = state_i;
    end
    if (hit && !supervisor_i && spr_rd_i) priv_viol_o = 1'b1;
  end

  always_comb begin
    assert_rsvd_zero_R2: assert (spr_rdata_o[DW-1:STATE_W] == '0);
  end
endmodule

// File: rtl/mcs_status_reg.sv
module mcs_status_reg
  import mcs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 me_en_i,
  input  logic [NUM_CAUSE-1:0] cause_set_i,
  input  logic [STATE_W-1:0]   clr_i,
  output mcs_state_t           state_o
);
  mcs_state_t clr_s;
  logic       any_evt;
  assign clr_s   = mcs_state_t'(clr_i);
  assign any_evt = |cause_set_i;

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             state_o.cause[g] <= 1'b0;
      else if (cause_set_i[g]) state_o.cause[g] <= 1'b1;
      else if (clr_s.cause[g]) state_o.cause[g] <= 1'b0;
    end

    assert_cause_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(state_o.cause[g]) |-> $past(clr_s.cause[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o.sum <= 1'b0;
      state_o.imp <= 1'b0;
    end else begin
      if (any_evt)          state_o.sum <= 1'b1;
      else if (clr_s.sum)   state_o.sum <= 1'b0;
      if (any_evt && !me_en_i) state_o.imp <= 1'b1;
      else if (clr_s.imp)   state_o.imp <= 1'b0;
    end
  end

  assert_sum_with_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt |=> state_o.sum && ((state_o.cause & $past(cause_set_i)) == $past(cause_set_i)));

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_evt && clr_s.sum) |=> state_o.sum);

  assert_imp_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o.imp) |-> $past(any_evt && !me_en_i));
endmodule

// File: rtl/mcs_unit.sv
module mcs_unit
  import mcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              me_en_i,
  input  logic              err_ifetch_bus_i,
  input  logic              err_dread_bus_i,
  input  logic              err_dwrite_bus_i,
  input  logic              err_tlb_par_i,
  input  logic              err_icache_par_i,
  input  logic              dc_par_err_i,
  input  logic              dc_flush_op_i,
  input  logic [SPR_W-1:0]  spr_num_i,
  input  logic              spr_rd_i,
  input  logic              spr_wr_i,
  input  logic [DATA_W-1:0] spr_wdata_i,
  input  logic              supervisor_i,
  output logic [DATA_W-1:0] spr_rdata_o,
  output logic              priv_viol_o,
  output logic              mc_irq_o
);
  logic [NUM_CAUSE-1:0] cause_set;
  logic [STATE_W-1:0]   clr;
  mcs_state_t           state;

  mcs_cause_decode u_dec (
    .err_ifetch_bus_i (err_ifetch_bus_i),
    .err_dread_bus_i  (err_dread_bus_i),
    .err_dwrite_bus_i (err_dwrite_bus_i),
    .err_tlb_par_i    (err_tlb_par_i),
    .err_icache_par_i (err_icache_par_i),
    .dc_par_err_i     (dc_par_err_i),
    .dc_flush_op_i    (dc_flush_op_i),
    .cause_set_o      (cause_set)
  );

  mcs_status_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .me_en_i     (me_en_i),
    .cause_set_i (cause_set),
    .clr_i       (clr),
    .state_o     (state)
  );

  mcs_spr_port #(
    .NUM_W  (SPR_W),
    .DW     (DATA_W),
    .MY_NUM (SPR_MCS)
  ) u_spr (
    .spr_num_i    (spr_num_i),
    .spr_rd_i     (spr_rd_i),
    .spr_wr_i     (spr_wr_i),
    .spr_wdata_i  (spr_wdata_i),
    .supervisor_i (supervisor_i),
    .state_i      (state),
    .clr_o        (clr),
    .spr_rdata_o  (spr_rdata_o),
    .priv_viol_o  (priv_viol_o)
  );

  assign mc_irq_o = state.sum & me_en_i;

  logic no_evt;
  assign no_evt = !(err_ifetch_bus_i | err_dread_bus_i | err_dwrite_bus_i |
                    err_tlb_par_i | err_icache_par_i | dc_par_err_i);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !mc_irq_o);

  assert_irq_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_irq_o |-> me_en_i);

  assert_dc_search_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state.cause[C_DSRCH]) |-> $past(dc_par_err_i && !dc_flush_op_i));

  assert_dc_flush_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state.cause[C_DFLUSH]) |-> $past(dc_par_err_i && dc_flush_op_i));

  assert_user_write_noop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_wr_i && !supervisor_i && no_evt) |=> $stable(state));

  assert_foreign_num_noop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_num_i != SPR_MCS && no_evt) |=> $stable(state));
endmodule

// File: tb/sim_mcs_unit.sv
module sim_mcs_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        me_en_i = 1'b1;
  logic [4:0]  err5 = '0;
  logic        dc_par_err_i = 1'b0;
  logic        dc_flush_op_i = 1'b0;
  logic [9:0]  spr_num_i = 10'h23C;
  logic        spr_rd_i = 1'b0;
  logic        spr_wr_i = 1'b0;
  logic [31:0] spr_wdata_i = '0;
  logic        supervisor_i = 1'b1;
  logic [31:0] spr_rdata_o;
  logic        priv_viol_o;
  logic        mc_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  mcs_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .me_en_i(me_en_i),
    .err_ifetch_bus_i(err5[0]), .err_dread_bus_i(err5[1]), .err_dwrite_bus_i(err5[2]),
    .err_tlb_par_i(err5[3]), .err_icache_par_i(err5[4]),
    .dc_par_err_i(dc_par_err_i), .dc_flush_op_i(dc_flush_op_i),
    .spr_num_i(spr_num_i), .spr_rd_i(spr_rd_i), .spr_wr_i(spr_wr_i),
    .spr_wdata_i(spr_wdata_i), .supervisor_i(supervisor_i),
    .spr_rdata_o(spr_rdata_o), .priv_viol_o(priv_viol_o), .mc_irq_o(mc_irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic rd(input logic sup, input logic [9:0] num,
                    output logic [31:0] d, output logic v);
    spr_num_i = num; supervisor_i = sup; spr_rd_i = 1'b1;
    #1; d = spr_rdata_o; v = priv_viol_o;
    #1; spr_rd_i = 1'b0; spr_num_i = 10'h23C; supervisor_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic sup, input logic [9:0] num, input logic [31:0] d);
    spr_num_i = num; supervisor_i = sup; spr_wr_i = 1'b1; spr_wdata_i = d;
    @(negedge clk_i);
    spr_wr_i = 1'b0; spr_wdata_i = '0; spr_num_i = 10'h23C; supervisor_i = 1'b1;
  endtask

  task automatic pulse(input logic [4:0] e, input logic dc, input logic fl);
    err5 = e; dc_par_err_i = dc; dc_flush_op_i = fl;
    @(negedge clk_i);
    err5 = '0; dc_par_err_i = 1'b0; dc_flush_op_i = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(1'b1, 10'h23C, d, v);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    check("R1 irq in reset", {31'd0, mc_irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(1'b1, 10'h23C, d, v);
    check("R1 status after reset", d, 32'd0);
  endtask

  task automatic t_single_sources;
    for (int i = 0; i < 5; i++) begin
      me_en_i = 1'b1;
      pulse(5'(1 << i), 1'b0, 1'b0);
      check("R4 irq on enabled event", {31'd0, mc_irq_o}, 32'd1);
      read_expect("R2 R3 single cause", 32'h1 | (32'h2 << i));
      wr(1'b1, 10'h23C, 32'h1FF);
      read_expect("R7 full clear", 32'h0);
    end
  endtask

  task automatic t_dcache;
    pulse(5'd0, 1'b1, 1'b0);
    read_expect("R6 search parity bit6", 32'h41);
    wr(1'b1, 10'h23C, 32'h1FF);
    pulse(5'd0, 1'b1, 1'b1);
    read_expect("R6 flush parity bit7", 32'h81);
    wr(1'b1, 10'h23C, 32'h1FF);
  endtask

  task automatic t_multi;
    pulse(5'b10101, 1'b1, 1'b1);
    read_expect("R3 simultaneous causes", 32'hAB);
    pulse(5'b00010, 1'b0, 1'b0);
    read_expect("R7 new event keeps old causes", 32'hAF);
    wr(1'b1, 10'h23C, 32'h1FF);
  endtask

  task automatic t_imprecise;
    me_en_i = 1'b0;
    pulse(5'b01000, 1'b0, 1'b0);
    #1; check("R4 irq masked", {31'd0, mc_irq_o}, 32'd0);
    read_expect("R5 imprecise on disabled event", 32'h111);
    me_en_i = 1'b1; #1;
    check("R4 irq when enable rises", {31'd0, mc_irq_o}, 32'd1);
    @(negedge clk_i);
    wr(1'b1, 10'h23C, 32'h1FF);
    pulse(5'b00001, 1'b0, 1'b0);
    read_expect("R5 no imprecise when enabled", 32'h3);
    me_en_i = 1'b0;
    pulse(5'b00100, 1'b0, 1'b0);
    read_expect("R5 imprecise with summary already set", 32'h10B);
    me_en_i = 1'b1;
    wr(1'b1, 10'h23C, 32'h1FF);
  endtask

  task automatic t_partial_clear;
    pulse(5'b10010, 1'b0, 1'b0);
    wr(1'b1, 10'h23C, 32'h1);
    #1; check("R7 irq drops on summary clear", {31'd0, mc_irq_o}, 32'd0);
    read_expect("R7 causes survive summary clear", 32'h24);
    wr(1'b1, 10'h23C, 32'hFFFF_FFFF);
    read_expect("R2 reserved bits stay zero", 32'h0);
  endtask

  task automatic t_set_wins;
    pulse(5'b00001, 1'b0, 1'b0);
    spr_wr_i = 1'b1; spr_wdata_i = 32'h1FF; err5 = 5'b00001;
    @(negedge clk_i);
    spr_wr_i = 1'b0; spr_wdata_i = '0; err5 = '0;
    read_expect("R8 set beats clear", 32'h3);
    wr(1'b1, 10'h23C, 32'h1FF);
  endtask

  task automatic t_user_and_foreign;
    logic [31:0] d; logic v;
    pulse(5'b00010, 1'b0, 1'b0);
    rd(1'b0, 10'h23C, d, v);
    check("R9 user read data", d, 32'h0);
    check("R9 user read violation", {31'd0, v}, 32'd1);
    wr(1'b0, 10'h23C, 32'h1FF);
    read_expect("R9 user write ignored", 32'h5);
    rd(1'b1, 10'h23D, d, v);
    check("R10 foreign read data", d, 32'h0);
    check("R10 foreign read no violation", {31'd0, v}, 32'd0);
    wr(1'b1, 10'h03C, 32'h1FF);
    read_expect("R10 foreign write ignored", 32'h5);
    rd(1'b1, 10'h23C, d, v);
    check("R9 supervisor read no violation", {31'd0, v}, 32'd0);
  endtask

  task automatic t_reset_mid;
    rst_ni = 1'b0; #1;
    check("R1 irq drops in reset", {31'd0, mc_irq_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    read_expect("R1 status cleared by reset", 32'h0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_single_sources();
    t_dcache();
    t_multi();
    t_imprecise();
    t_partial_clear();
    t_set_wins();
    t_user_and_foreign();
    t_reset_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule